// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of Ethernet PHYs over a two-wire MDIO bus. The host sees three 16-bit registers behind a small select/write/read port. A command register holds the PHY address, the PHY register number and a two-bit operation code. A transmit register holds the data for write frames. A receive register returns the data of the last read frame.

One write to the command register starts a complete 64-bit management frame. The block divides the system clock down to MDC and shifts the frame out MSB first. On a read it releases the data line so the PHY can drive it, and it collects the 16 returned bits. While a frame is running, the idle flag in the command register reads 0. The host polls that flag before it issues the next command.

The data line leaves the block as three separate pins: an output value, an output enable and the input value. These connect to a bidirectional pad.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register reads 16'h1000, which is the idle flag (bit 12) set and all command fields zero. After reset the receive register reads 0, MDC is low and the data line is released (mdioOe = 0).
- R2: regSel selects a register: 0 is the command/status register, 1 is the transmit-data register and 2 is the receive-data register. Command bits are: register number in 4:0, PHY address in 9:5, opcode in 11:10, idle flag in 12. Bits 15:13 read 0. Bits 11:0 read back the last accepted command, and the transmit register reads back the last value written to it.
- R3: A command write with opcode 2'b01 while idle starts a write frame of 64 MDC cycles. The frame is 32 ones, then 01, the opcode, the PHY address, the register number, the turnaround 10 and the 16 transmit bits, all MSB first, with mdioOe high throughout.
- R4: A command write with opcode 2'b10 while idle starts a read frame. Its first 46 bits match the write layout with opcode 10. mdioOe is low for the two turnaround bits and the 16 data bits.
- R5: During a read frame the block samples mdioIn on the 16 MDC rising edges of the data phase, MSB first. The receive register takes the 16 bits at once when the frame ends and otherwise holds its value, including during frames.
- R6: MDC is high for HALF_DIV system clocks and low for HALF_DIV system clocks in each bit. MDC stays low while idle. mdioOut changes during a frame only together with a falling MDC edge.
- R7: The idle flag reads 0 from the clock edge that accepts a command until 128*HALF_DIV clock edges later, when it returns to 1.
- R8: A command write while the idle flag is 0 is ignored. The running frame, the command readback and the frame count are unchanged.
- R9: A command write with opcode 2'b00 or 2'b11 is ignored. No frame starts, the idle flag stays 1 and the command readback keeps its value.
- R10: A transmit register write during a frame updates the register but does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select for reads and writes |
| regWr | input | 1 | Write strobe for the selected register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto the data line |
| mdioOe | output | 1 | Output enable for the data line pad |
| mdioIn | input | 1 | Value seen on the data line |

## Verification
The assertions assume the host issues commands only through the register port with a clean reset. They also assume mdioIn is sampled only on MDC rising edges, so its value between edges is free. The bench's PHY responder changes mdioIn only just after MDC falls, and the host drives the register port half a cycle away from the active edge. The bench places its disallowed stimulus on purpose: commands during a busy frame, commands with invalid opcodes and transmit writes mid-frame. All of these go through the normal port so that their lack of effect shows in the readback and in the frames on the wire.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int TA_START   = 46;
  localparam int DATA_START = 48;
  localparam int IDLE_POS   = 12;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_TX  = 2'd1;
  localparam logic [1:0] SEL_RX  = 2'd2;

  typedef struct packed {
    logic load;    // capture a new frame
    logic shift;   // advance to the next bit (falling MDC)
    logic sample;  // take one read bit (rising MDC)
    logic commit;  // publish collected read data
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_master_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWr,
  input  logic [1:0]   cmdOp,
  output mdioStrobes_t strb,
  output logic         mdc,
  output logic         mdioOe,
  output logic         busy
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic [CW-1:0] divCnt;
  logic [BW-1:0] bitIdx;
  logic          mdcQ;
  logic          readQ;
  logic          start;
  logic          halfEnd;
  logic          lastBit;

  assign start   = cmdWr && !busy && (cmdOp == OP_WRITE || cmdOp == OP_READ);
  assign halfEnd = busy && (divCnt == CW'(HALF_DIV - 1));
  assign lastBit = (bitIdx == BW'(FRAME_BITS - 1));

  always_comb begin
    strb        = '0;
    strb.load   = start;
    strb.sample = halfEnd && !mdcQ && readQ && (bitIdx >= BW'(DATA_START));
    strb.shift  = halfEnd && mdcQ && !lastBit;
    strb.commit = halfEnd && mdcQ && lastBit && readQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      readQ  <= 1'b0;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      readQ  <= (cmdOp == OP_READ);
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      if (halfEnd) begin
        divCnt <= '0;
        mdcQ   <= !mdcQ;
        if (mdcQ) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc    = mdcQ;
  assign mdioOe = busy && (!readQ || bitIdx < BW'(TA_START));

  // R6: the clock is parked low whenever no frame runs
  p_mdc_low_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdcQ);

  // R8: the operation of a running frame never changes
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(readQ));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_master_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mdioStrobes_t strb,
  input  logic         busy,
  input  logic [1:0]   regSel,
  input  logic         regWr,
  input  logic [15:0]  regWrData,
  output logic [15:0]  regRdData,
  input  logic         mdioIn,
  output logic         mdioOut
);
  logic [FRAME_BITS-1:0] shiftQ;
  logic [DATA_BITS-1:0]  txData;
  logic [DATA_BITS-1:0]  rxShift;
  logic [DATA_BITS-1:0]  rxData;
  logic [11:0]           cmdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '1;
      txData  <= '0;
      rxShift <= '0;
      rxData  <= '0;
      cmdQ    <= '0;
    end else begin
      if (regWr && regSel == SEL_TX) txData <= regWrData;
      if (strb.load) begin
        cmdQ   <= regWrData[11:0];
        shiftQ <= {{32{1'b1}}, 2'b01, regWrData[11:10], regWrData[9:5],
                   regWrData[4:0], 2'b10, txData};
      end else if (strb.shift) begin
        shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b1};
      end
      if (strb.sample) rxShift <= {rxShift[DATA_BITS-2:0], mdioIn};
      if (strb.commit) rxData  <= rxShift;
    end
  end

  assign mdioOut = shiftQ[FRAME_BITS-1];

  always_comb begin
    case (regSel)
      SEL_CMD: regRdData = {3'b000, !busy, cmdQ};
      SEL_TX:  regRdData = txData;
      SEL_RX:  regRdData = rxData;
      default: regRdData = '0;
    endcase
  end

  // R5: received data only moves at the end of a read frame
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $past(strb.commit));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        regWr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobes_t strb;
  logic         busy;
  logic         cmdWr;

  assign cmdWr = regWr && (regSel == SEL_CMD);

  mdio_seq #(.HALF_DIV(HALF_DIV)) i_seq (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdOp(regWrData[11:10]),
    .strb(strb), .mdc(mdc), .mdioOe(mdioOe), .busy(busy)
  );

  mdio_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .regSel(regSel), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .mdioIn(mdioIn), .mdioOut(mdioOut)
  );

  // R6: within a frame the data line only moves with a falling MDC edge
  p_mdo_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !$stable(mdioOut) |-> $fell(mdc));

  // R4: the data line is never driven while MDC is idle
  p_no_drive_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int HALF = 4;
  localparam int FRAME_CLKS = 128 * HALF;

  typedef struct {
    logic [63:0] bits;
    logic        isRd;
    logic [15:0] resp;
  } frameItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int tests = 0;
  int fails = 0;
  int framesSeen = 0;
  int framesExp = 0;
  bit finished = 0;
  frameItem_t expQ[$];

  always #5 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) i_mdio_master (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] mkFrame(logic [1:0] op, logic [4:0] phy,
                                          logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic busWrite(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    regSel = sel; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRead(logic [1:0] sel, output logic [15:0] d);
    regSel = sel;
    #1;
    d = regRdData;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    regSel = 2'd0;
    #1;
    while (regRdData[12] == 1'b0 && n < 100000) begin
      @(negedge clk);
      #1;
      n++;
    end
  endtask

  task automatic pushFrame(logic [1:0] op, logic [4:0] phy, logic [4:0] rg,
                           logic [15:0] d, logic [15:0] resp);
    frameItem_t it;
    it.bits = mkFrame(op, phy, rg, d);
    it.isRd = (op == 2'b10);
    it.resp = resp;
    expQ.push_back(it);
    framesExp++;
  endtask

  // Monitor: PHY responder and scoreboard for frames on the wire
  initial begin
    forever begin
      frameItem_t exp;
      logic [63:0] gotOut, gotOe, expOe;
      time tRise, tFall;
      @(posedge mdc);
      #1;
      if (expQ.size() == 0) begin
        tests++; fails++;
        $display("FAIL R8/R9: unexpected frame got 1 expected 0");
        exp.bits = '0; exp.isRd = 1'b0; exp.resp = '0;
      end else begin
        exp = expQ.pop_front();
      end
      tRise = $time;
      for (int i = 0; i < 64; i++) begin
        if (i > 0) begin
          @(posedge mdc);
          #1;
        end
        gotOut[63-i] = mdioOut;
        gotOe[63-i]  = mdioOe;
        @(negedge mdc);
        #1;
        if (i == 0) tFall = $time;
        mdioIn = (exp.isRd && (i + 1) >= 48 && (i + 1) < 64) ? exp.resp[63-(i+1)] : 1'b1;
      end
      framesSeen++;
      check("R6 mdc high time", 64'(tFall - tRise), 64'(HALF * 10));
      if (exp.isRd) begin
        expOe = {46'h3FFF_FFFF_FFFF, 18'h0};
        check("R4 read header", gotOut[63:18], exp.bits[63:18]);
        check("R4 read release", gotOe, expOe);
      end else begin
        check("R3 write frame", gotOut, exp.bits);
        check("R3 write drive", gotOe, '1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int n;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd0, rd); check("R1 cmd reset", 64'(rd), 64'h1000);
    busRead(2'd2, rd); check("R1 rx reset", 64'(rd), 64'h0);
    check("R1 mdc low", 64'(mdc), 64'h0);
    check("R1 released", 64'(mdioOe), 64'h0);

    // R2 transmit readback
    busWrite(2'd1, 16'hA5C3);
    busRead(2'd1, rd); check("R2 tx readback", 64'(rd), 64'hA5C3);

    // R3 / R7 write frame
    pushFrame(2'b01, 5'h11, 5'h0A, 16'hA5C3, 16'h0);
    busWrite(2'd0, {4'h0, 2'b01, 5'h11, 5'h0A});
    busRead(2'd0, rd); check("R7 busy flag", 64'(rd), 64'(16'h0000 | {2'b01, 5'h11, 5'h0A}));
    waitIdle(n); check("R7 frame length", 64'(n), 64'(FRAME_CLKS));
    busRead(2'd0, rd); check("R2 cmd readback", 64'(rd), 64'(16'h1000 | {2'b01, 5'h11, 5'h0A}));

    // R4 / R5 read frame
    pushFrame(2'b10, 5'h03, 5'h02, 16'h0, 16'hBEEF);
    busWrite(2'd0, {4'h0, 2'b10, 5'h03, 5'h02});
    waitIdle(n); check("R7 read frame length", 64'(n), 64'(FRAME_CLKS));
    busRead(2'd2, rd); check("R5 rx data", 64'(rd), 64'hBEEF);

    // R5 hold across a write frame
    busWrite(2'd1, 16'h1234);
    pushFrame(2'b01, 5'h1F, 5'h00, 16'h1234, 16'h0);
    busWrite(2'd0, {4'h0, 2'b01, 5'h1F, 5'h00});
    waitIdle(n);
    busRead(2'd2, rd); check("R5 rx hold after write", 64'(rd), 64'hBEEF);

    // R5 hold during a read frame, update at end
    pushFrame(2'b10, 5'h0C, 5'h1B, 16'h0, 16'h0F0F);
    busWrite(2'd0, {4'h0, 2'b10, 5'h0C, 5'h1B});
    repeat (FRAME_CLKS - 20) @(negedge clk);
    busRead(2'd2, rd); check("R5 rx hold mid read", 64'(rd), 64'hBEEF);
    waitIdle(n);
    busRead(2'd2, rd); check("R5 rx update", 64'(rd), 64'h0F0F);

    // R8 command while busy
    pushFrame(2'b01, 5'h01, 5'h01, 16'h1234, 16'h0);
    busWrite(2'd0, {4'h0, 2'b01, 5'h01, 5'h01});
    repeat (100) @(negedge clk);
    busWrite(2'd0, {4'h0, 2'b10, 5'h1F, 5'h1F});
    busRead(2'd0, rd); check("R8 cmd unchanged", 64'(rd), 64'({2'b01, 5'h01, 5'h01}));
    waitIdle(n);
    repeat (40) @(negedge clk);
    check("R8 no second frame", 64'(mdc), 64'h0);
    busRead(2'd0, rd); check("R8 idle after", 64'(rd), 64'(16'h1000 | {2'b01, 5'h01, 5'h01}));

    // R9 invalid opcodes
    busWrite(2'd0, {4'h0, 2'b00, 5'h07, 5'h07});
    busWrite(2'd0, {4'h0, 2'b11, 5'h08, 5'h08});
    repeat (3 * HALF) @(negedge clk);
    busRead(2'd0, rd); check("R9 ignored opcodes", 64'(rd), 64'(16'h1000 | {2'b01, 5'h01, 5'h01}));
    check("R9 mdc idle", 64'(mdc), 64'h0);
    check("R9 released", 64'(mdioOe), 64'h0);

    // R10 transmit write mid-frame
    busWrite(2'd1, 16'h5A5A);
    pushFrame(2'b01, 5'h15, 5'h0E, 16'h5A5A, 16'h0);
    busWrite(2'd0, {4'h0, 2'b01, 5'h15, 5'h0E});
    repeat (50) @(negedge clk);
    busWrite(2'd1, 16'hFFFF);
    waitIdle(n);
    busRead(2'd1, rd); check("R10 tx updated", 64'(rd), 64'hFFFF);

    repeat (20) @(negedge clk);
    check("R8 frame count", 64'(framesSeen), 64'(framesExp));
    check("R3 queue drained", 64'(expQ.size()), 64'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule